// File: doc/BRIEF.md
# Line-State Controller with a Readable Stale State

This block tracks the coherence state of every line in a small, fully tracked cache for one core. It follows the familiar four-state protocol (Invalid, Shared, Exclusive, Modified) and adds a fifth state, Stale. A Shared or Exclusive copy enters Stale when another core takes ownership of the line. It does not drop to Invalid. Relaxed loads may keep reading a Stale copy. Ordered loads, stores and any move back to a valid state must fetch the data again.

Stale copies leave that state in two ways. An acquire/consume barrier pulse sends every Stale line to Invalid in a single cycle. A per-line age counter also invalidates any Stale copy after a fixed number of cycles, so a core that spins on a relaxed load always sees the new value in the end.

Each cycle the controller takes at most one local request and one snooped request. It answers the local request with a hit flag and, when needed, a bus read or read-for-ownership. It answers the snoop with data-supply and writeback flags, and it shows every line's state on a flat vector. The bus transaction is taken to complete in the same cycle it is requested.

Top module: `stale_mesi_ctrl`

## Requirements
- R1: After reset every line is Invalid (code 0), `barrier_done` is low, and no bus or snoop response is asserted while the inputs are idle.
- R2: Each line's state lies at bits [3i+2:3i] of `line_states`, coded Invalid=0, Shared=1, Exclusive=2, Modified=3, Stale=4. A load to an Invalid line misses and raises a bus read (`bus_req_valid`=1, `bus_req_rfo`=0). The line becomes Exclusive if `fill_unshared` is high and Shared if it is low.
- R3: A store to an Exclusive or Modified line hits with no bus request. A store to a Shared, Invalid or Stale line misses and raises a read-for-ownership. In both cases the line ends Modified.
- R4: A snooped read of a Modified line asserts `snp_supply` and moves the line to Shared. A snooped read of an Exclusive line moves it to Shared. Other states are unchanged.
- R5: A snooped read-for-ownership moves a Shared or Exclusive line to Stale. It moves a Modified line to Stale and asserts `snp_writeback`. Invalid and Stale lines are unchanged.
- R6: A relaxed load to a Stale line hits, raises no bus request and leaves the line Stale.
- R7: An ordered load to a Stale line misses, raises a bus read and refetches the line into Shared or Exclusive.
- R8: A barrier pulse moves every Stale line to Invalid at the next clock edge and leaves other lines unchanged. `barrier_done` is high during exactly the one cycle after the pulse. A local request in the barrier cycle is evaluated after the purge.
- R9: A barrier with no local request raises no bus request, whether or not any line is Stale. Its completion latency does not depend on how many lines are Stale.
- R10: A Stale line becomes Invalid exactly AGE_LIMIT cycles after it enters Stale. The count restarts each time the line enters Stale again.
- R11: When a snoop and a local request target the same line in one cycle, the snoop is applied first. The local request is then judged against the resulting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Local request present |
| req_line | input | LINE_W | Line targeted by the local request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_ordered | input | 1 | Load is ordered (acquire/consume); 0 = relaxed |
| fill_unshared | input | 1 | No other core holds the line being fetched by a read |
| snp_valid | input | 1 | Snooped request present |
| snp_line | input | LINE_W | Line targeted by the snoop |
| snp_rfo | input | 1 | Snoop is read-for-ownership; 0 = plain read |
| barrier | input | 1 | Acquire/consume barrier pulse |
| rsp_hit | output | 1 | Local request served without a bus transaction |
| bus_req_valid | output | 1 | Local request needs a bus transaction |
| bus_req_rfo | output | 1 | Bus transaction is read-for-ownership |
| snp_supply | output | 1 | This core supplies data for the snooped read |
| snp_writeback | output | 1 | This core writes back dirty data for the snoop |
| barrier_done | output | 1 | Barrier purge complete (one cycle after the pulse) |
| line_states | output | 3*NUM_LINES | Per-line state codes |

## Verification
A wrong internal state reaches the ports in the same cycle as the next request to that line, through `rsp_hit` and the bus request flags. It is also visible one cycle after any transition on `line_states`. An age counter that is off by even one cycle shifts the Stale-to-Invalid edge by that cycle, so the bench samples the state exactly at AGE_LIMIT-1 and at AGE_LIMIT cycles after entry, both on a fresh entry and on a re-entry. A purge applied in the wrong order against snoops or local requests shows up as a hit or miss flag that differs from the expected one in the barrier cycle.

// File: rtl/smesi_pkg.sv
package smesi_pkg;
  typedef enum logic [2:0] {
    LS_INV   = 3'd0,
    LS_SHR   = 3'd1,
    LS_EXC   = 3'd2,
    LS_MOD   = 3'd3,
    LS_STALE = 3'd4
  } line_st_e;
endpackage

// File: rtl/smesi_age.sv
// Per-line age counter: counts cycles spent in the stale state.
module smesi_age #(
  parameter int AGE_LIMIT = 1000,
  localparam int AGE_W = (AGE_LIMIT > 2) ? $clog2(AGE_LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expire
);
  logic [AGE_W-1:0] cnt_q, cnt_d;
  logic             cnt_upd;

  assign expire = (cnt_q == AGE_W'(AGE_LIMIT - 1));

  always_comb begin
    cnt_upd = clr | (en & ~expire);
    cnt_d   = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_upd) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/smesi_line.sv
// One tracked line: snoop first, then purge/aging, then local request.
module smesi_line
  import smesi_pkg::*;
#(
  parameter int AGE_LIMIT = 1000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     snp_sel,
  input  logic     snp_rfo,
  input  logic     purge,
  input  logic     req_sel,
  input  logic     req_store,
  input  logic     req_ordered,
  input  logic     fill_unshared,
  output line_st_e state,
  output logic     loc_hit,
  output logic     loc_bus,
  output logic     loc_rfo,
  output logic     snp_supply,
  output logic     snp_wb
);
  line_st_e st_q, st_d, after_snp, after_purge, fill_st;
  logic     expire, st_upd, age_clr, age_en;

  assign fill_st = fill_unshared ? LS_EXC : LS_SHR;

  always_comb begin
    after_snp  = st_q;
    snp_supply = 1'b0;
    snp_wb     = 1'b0;
    if (snp_sel) begin
      if (snp_rfo) begin
        case (st_q)
          LS_MOD: begin after_snp = LS_STALE; snp_wb = 1'b1; end
          LS_EXC, LS_SHR: after_snp = LS_STALE;
          default: ;
        endcase
      end else begin
        case (st_q)
          LS_MOD: begin after_snp = LS_SHR; snp_supply = 1'b1; end
          LS_EXC: after_snp = LS_SHR;
          default: ;
        endcase
      end
    end

    after_purge = after_snp;
    if (after_snp == LS_STALE && (purge || (st_q == LS_STALE && expire)))
      after_purge = LS_INV;

    st_d    = after_purge;
    loc_hit = 1'b0;
    loc_bus = 1'b0;
    loc_rfo = 1'b0;
    if (req_sel) begin
      if (req_store) begin
        loc_hit = (after_purge == LS_EXC) || (after_purge == LS_MOD);
        loc_bus = ~loc_hit;
        loc_rfo = ~loc_hit;
        st_d    = LS_MOD;
      end else begin
        case (after_purge)
          LS_INV: begin loc_bus = 1'b1; st_d = fill_st; end
          LS_STALE:
            if (req_ordered) begin loc_bus = 1'b1; st_d = fill_st; end
            else loc_hit = 1'b1;
          default: loc_hit = 1'b1;
        endcase
      end
    end
  end

  assign st_upd  = (st_d != st_q);
  assign age_clr = (st_d == LS_STALE) && (st_q != LS_STALE);
  assign age_en  = (st_q == LS_STALE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= LS_INV;
    else if (st_upd) st_q <= st_d;
  end

  smesi_age #(.AGE_LIMIT(AGE_LIMIT)) u_age (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (age_clr),
    .en     (age_en),
    .expire (expire)
  );

  assign state = st_q;
endmodule

// File: rtl/stale_mesi_ctrl.sv
module stale_mesi_ctrl
  import smesi_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int AGE_LIMIT = 1000,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [LINE_W-1:0]      req_line,
  input  logic                   req_store,
  input  logic                   req_ordered,
  input  logic                   fill_unshared,
  input  logic                   snp_valid,
  input  logic [LINE_W-1:0]      snp_line,
  input  logic                   snp_rfo,
  input  logic                   barrier,
  output logic                   rsp_hit,
  output logic                   bus_req_valid,
  output logic                   bus_req_rfo,
  output logic                   snp_supply,
  output logic                   snp_writeback,
  output logic                   barrier_done,
  output logic [3*NUM_LINES-1:0] line_states
);
  logic [1:0]           rs_q;
  logic                 core_rst_n;
  logic                 done_q;
  logic [NUM_LINES-1:0] hit_v, bus_v, rfo_v, sup_v, wb_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign core_rst_n = rs_q[1];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    line_st_e st;
    smesi_line #(.AGE_LIMIT(AGE_LIMIT)) u_line (
      .clk           (clk),
      .rst_n         (core_rst_n),
      .snp_sel       (core_rst_n & snp_valid & (snp_line == LINE_W'(i))),
      .snp_rfo       (snp_rfo),
      .purge         (core_rst_n & barrier),
      .req_sel       (core_rst_n & req_valid & (req_line == LINE_W'(i))),
      .req_store     (req_store),
      .req_ordered   (req_ordered),
      .fill_unshared (fill_unshared),
      .state         (st),
      .loc_hit       (hit_v[i]),
      .loc_bus       (bus_v[i]),
      .loc_rfo       (rfo_v[i]),
      .snp_supply    (sup_v[i]),
      .snp_wb        (wb_v[i])
    );
    assign line_states[3*i +: 3] = st;
  end

  assign rsp_hit       = |hit_v;
  assign bus_req_valid = |bus_v;
  assign bus_req_rfo   = |rfo_v;
  assign snp_supply    = |sup_v;
  assign snp_writeback = |wb_v;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) done_q <= 1'b0;
    else             done_q <= barrier;
  end
  assign barrier_done = done_q;
endmodule

// File: rtl/smesi_chk.sv
module smesi_chk #(
  parameter int NUM_LINES = 4,
  parameter int AGE_LIMIT = 1000,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic [LINE_W-1:0]      req_line,
  input logic                   req_store,
  input logic                   req_ordered,
  input logic                   snp_valid,
  input logic [LINE_W-1:0]      snp_line,
  input logic                   snp_rfo,
  input logic                   barrier,
  input logic                   rsp_hit,
  input logic                   bus_req_valid,
  input logic                   bus_req_rfo,
  input logic                   snp_supply,
  input logic                   snp_writeback,
  input logic                   barrier_done,
  input logic [3*NUM_LINES-1:0] line_states
);
  function automatic logic [2:0] st_of(input logic [3*NUM_LINES-1:0] v, input int idx);
    return 3'(v >> (3 * idx));
  endfunction

  function automatic logic any_stale(input logic [3*NUM_LINES-1:0] v);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) r |= (st_of(v, i) == 3'd4);
    return r;
  endfunction

  logic same_line;
  assign same_line = req_valid && snp_valid && (req_line == snp_line);

  a_r8_done_next: assert property (@(posedge clk) disable iff (!rst_n)
    barrier |=> barrier_done);

  a_r8_purge_all: assert property (@(posedge clk) disable iff (!rst_n)
    barrier |=> !any_stale(line_states));

  a_r9_quiet_barrier: assert property (@(posedge clk) disable iff (!rst_n)
    (barrier && !req_valid) |-> !bus_req_valid);

  a_r7_ordered_refetch: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store && req_ordered && st_of(line_states, int'(req_line)) == 3'd4)
      |-> (bus_req_valid && !bus_req_rfo && !rsp_hit));

  a_r3_stale_store_rfo: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && st_of(line_states, int'(req_line)) == 3'd4)
      |-> (bus_req_valid && bus_req_rfo));

  a_r5_rfo_demotes: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_rfo && st_of(line_states, int'(snp_line)) == 3'd1 && !same_line)
      |=> (st_of(line_states, int'($past(snp_line))) == 3'd4));

  a_r4_modified_supplies: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_rfo && st_of(line_states, int'(snp_line)) == 3'd3)
      |-> (snp_supply && !snp_writeback));
endmodule

bind stale_mesi_ctrl smesi_chk #(.NUM_LINES(NUM_LINES), .AGE_LIMIT(AGE_LIMIT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_line      (req_line),
  .req_store     (req_store),
  .req_ordered   (req_ordered),
  .snp_valid     (snp_valid),
  .snp_line      (snp_line),
  .snp_rfo       (snp_rfo),
  .barrier       (barrier),
  .rsp_hit       (rsp_hit),
  .bus_req_valid (bus_req_valid),
  .bus_req_rfo   (bus_req_rfo),
  .snp_supply    (snp_supply),
  .snp_writeback (snp_writeback),
  .barrier_done  (barrier_done),
  .line_states   (line_states)
);

// File: tb/stale_mesi_ctrl_test.sv
module stale_mesi_ctrl_test;
  localparam int NL = 4;
  localparam int LW = 2;
  localparam int AL = 1000;
  localparam int I = 0, S = 1, E = 2, M = 3, T = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_store = 0, req_ordered = 0, fill_unshared = 0;
  logic snp_valid = 0, snp_rfo = 0, barrier = 0;
  logic [LW-1:0] req_line = '0, snp_line = '0;
  logic rsp_hit, bus_req_valid, bus_req_rfo, snp_supply, snp_writeback, barrier_done;
  logic [3*NL-1:0] line_states;

  int checks = 0;
  int failures = 0;
  logic o_hit, o_bus, o_rfo, o_sup, o_wb;

  always #4 clk = ~clk;

  stale_mesi_ctrl #(.NUM_LINES(NL), .AGE_LIMIT(AL)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
    .req_store(req_store), .req_ordered(req_ordered), .fill_unshared(fill_unshared),
    .snp_valid(snp_valid), .snp_line(snp_line), .snp_rfo(snp_rfo), .barrier(barrier),
    .rsp_hit(rsp_hit), .bus_req_valid(bus_req_valid), .bus_req_rfo(bus_req_rfo),
    .snp_supply(snp_supply), .snp_writeback(snp_writeback),
    .barrier_done(barrier_done), .line_states(line_states));

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int st(input int l);
    return int'(line_states[3*l +: 3]);
  endfunction

  // Drive one cycle of stimulus at a falling edge, capture the responses, clear.
  task automatic step(input logic rv, input int rl, input logic rs, input logic ro,
                      input logic fu, input logic sv, input int sl, input logic sr,
                      input logic bar);
    req_valid = rv; req_line = LW'(rl); req_store = rs; req_ordered = ro;
    fill_unshared = fu; snp_valid = sv; snp_line = LW'(sl); snp_rfo = sr; barrier = bar;
    #1;
    o_hit = rsp_hit; o_bus = bus_req_valid; o_rfo = bus_req_rfo;
    o_sup = snp_supply; o_wb = snp_writeback;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_store = 0; req_ordered = 0; fill_unshared = 0;
    snp_valid = 0; snp_rfo = 0; barrier = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic put(input int l, input int s);
    case (s)
      S: step(1, l, 0, 0, 0, 0, 0, 0, 0);
      E: step(1, l, 0, 0, 1, 0, 0, 0, 0);
      M: step(1, l, 1, 0, 0, 0, 0, 0, 0);
      T: begin step(1, l, 0, 0, 0, 0, 0, 0, 0); step(0, 0, 0, 0, 0, 1, l, 1, 0); end
      default: ;
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    failures++;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1 states", int'(line_states), 0);
    chk("R1 done", int'(barrier_done), 0);
    chk("R1 bus", int'(bus_req_valid | snp_supply | snp_writeback), 0);

    // Sweep start state x operation x line. ops: 0 relaxed ld, 1 ordered ld, 2 st, 3 snoop rd, 4 snoop rfo
    for (int l = 0; l < NL; l++) begin
      for (int s0 = 0; s0 < 5; s0++) begin
        for (int op = 0; op < 5; op++) begin
          int en, eh, eb, er, es, ew;
          string rq;
          do_reset();
          put(l, s0);
          chk("R2 setup", st(l), s0);
          en = s0; eh = 0; eb = 0; er = 0; es = 0; ew = 0;
          case (op)
            0: begin rq = (s0 == I) ? "R2 relaxed" : "R6 relaxed";
                 if (s0 == I) begin eb = 1; en = S; end else eh = 1; end
            1: begin rq = (s0 == I) ? "R2 ordered" : "R7 ordered";
                 if (s0 == I || s0 == T) begin eb = 1; en = S; end else eh = 1; end
            2: begin rq = "R3 store"; en = M;
                 if (s0 == E || s0 == M) eh = 1; else begin eb = 1; er = 1; end end
            3: begin rq = "R4 snoop read";
                 if (s0 == M) begin en = S; es = 1; end else if (s0 == E) en = S; end
            default: begin rq = "R5 snoop rfo";
                 if (s0 == M) begin en = T; ew = 1; end else if (s0 == E || s0 == S) en = T; end
          endcase
          if (op < 3) step(1, l, op == 2, op == 1, 0, 0, 0, 0, 0);
          else        step(0, 0, 0, 0, 0, 1, l, op == 4, 0);
          chk({rq, " hit"}, int'(o_hit), eh);
          chk({rq, " bus"}, int'(o_bus), eb);
          chk({rq, " rfo"}, int'(o_rfo), er);
          chk({rq, " supply"}, int'(o_sup), es);
          chk({rq, " writeback"}, int'(o_wb), ew);
          chk({rq, " next"}, st(l), en);
          for (int k = 0; k < NL; k++)
            if (k != l) chk({rq, " other line"}, st(k), I);
        end
      end
    end

    // R2: unshared fill goes Exclusive; ordered refetch of stale too (R7)
    do_reset();
    step(1, 3, 0, 0, 1, 0, 0, 0, 0);
    chk("R2 fill excl", st(3), E);
    put(3, T);
    chk("R7 setup", st(3), T);
    step(1, 3, 0, 1, 1, 0, 0, 0, 0);
    chk("R7 refetch excl", st(3), E);

    // R8: barrier purges only stale lines
    do_reset();
    put(0, S); put(1, T); put(2, M); put(3, T);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R9 no bus in barrier", int'(o_bus), 0);
    chk("R8 line0", st(0), S);
    chk("R8 line1", st(1), I);
    chk("R8 line2", st(2), M);
    chk("R8 line3", st(3), I);
    chk("R8 done high", int'(barrier_done), 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 done one cycle", int'(barrier_done), 0);

    // R8: local relaxed load in barrier cycle sees the purge
    put(2, T);
    step(1, 2, 0, 0, 0, 0, 0, 0, 1);
    chk("R8 load after purge hit", int'(o_hit), 0);
    chk("R8 load after purge bus", int'(o_bus), 1);
    chk("R8 load after purge state", st(2), S);

    // R9: barrier with no stale lines
    do_reset();
    put(0, S); put(1, E); put(2, M);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R9 no bus", int'(o_bus), 0);
    chk("R9 done", int'(barrier_done), 1);
    chk("R9 states kept", int'(line_states), (M << 6) | (E << 3) | S);

    // R11: snoop first, then the local request on the same line
    do_reset();
    put(2, M);
    step(1, 2, 1, 0, 0, 1, 2, 1, 0);
    chk("R11 writeback", int'(o_wb), 1);
    chk("R11 store misses", int'(o_hit), 0);
    chk("R11 store rfo", int'(o_bus & o_rfo), 1);
    chk("R11 ends modified", st(2), M);
    step(1, 2, 0, 0, 0, 1, 2, 0, 0);
    chk("R11 supply", int'(o_sup), 1);
    chk("R11 load hits", int'(o_hit), 1);
    chk("R11 ends shared", st(2), S);
    step(1, 2, 0, 1, 0, 1, 2, 1, 0);
    chk("R11 ordered on fresh stale misses", int'(o_bus), 1);
    chk("R11 ordered refetch", st(2), S);

    // R10: aging, fresh entry
    do_reset();
    put(1, T);
    repeat (AL - 1) @(posedge clk);
    @(negedge clk);
    chk("R10 stale at limit-1", st(1), T);
    @(posedge clk); @(negedge clk);
    chk("R10 invalid at limit", st(1), I);

    // R10: counter restarts on re-entry
    put(0, T);
    repeat (500) @(posedge clk);
    @(negedge clk);
    step(1, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R10 refetched", st(0), S);
    step(0, 0, 0, 0, 0, 1, 0, 1, 0);
    chk("R10 reentered", st(0), T);
    repeat (AL - 1) @(posedge clk);
    @(negedge clk);
    chk("R10 reentry stale at limit-1", st(0), T);
    @(posedge clk); @(negedge clk);
    chk("R10 reentry invalid at limit", st(0), I);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule